// File: doc/BRIEF.md
# Unit Serial Number Page Responder

This block sits behind a mass-storage command path. It takes a six-byte SCSI command block, one byte per strobe. It decides whether the command asks for the vital-product-data page that carries the unit serial number. When it does, the block pulls the serial-number character field of a drive's identify data through a byte-wide ready/valid port. It strips that field of every null and space character and keeps the survivors in a small buffer. It then streams the page back one byte at a time on a ready/valid output.

The page opens with a four-byte header: a device byte built from two static configuration inputs, the page code, a zero byte and the length byte. The compacted serial characters follow. The stream is cut short at the allocation length carried in the command. An inquiry that asks for any other vital-product-data page raises a one-cycle flag and sends nothing. Other commands, and plain inquiries, are left to the rest of the system and produce nothing here.

Top module: `sn_page_responder`

## Requirements
- R1: Command bytes are numbered 0 to 5 in arrival order. Only a command whose byte 0 is 12h is acted on. Any other opcode yields no response byte, no flag pulse and no identify read.
- R2: A command with byte 0 = 12h, byte 1 bit 0 = 1 and byte 2 = 80h is a serial page request. All other bits of byte 1 are don't-care. If such a request has a nonzero allocation length, the block reads the identify field and then sends the page.
- R3: Response byte 0 is the qualifier input in bits 7:5 and the device type input in bits 4:0.
- R4: Response byte 1 is 80h and response byte 2 is 00h.
- R5: Identify characters equal to 00h or 20h are discarded. Every other value, 01h, 1Fh, 21h and FFh included, is kept in arrival order and sent from response byte 4 onward.
- R6: Response byte 3 is the number of characters kept, from 0 up to FIELD_LEN. The input "713 740" padded with spaces gives 6.
- R7: The number of response bytes is the smaller of 4 + kept count and the allocation length in command byte 4. A length of 0 gives no bytes and no identify read.
- R8: An inquiry with byte 1 bit 0 = 1 and byte 2 not 80h drives unsup_pulse high for exactly one cycle. It sends no data and reads no identify characters.
- R9: An inquiry with byte 1 bit 0 = 0 produces no response byte, no flag pulse and no identify read.
- R10: While rsp_valid is high and rsp_ready is low, rsp_valid stays high and rsp_byte holds its value.
- R11: Command bytes that arrive while a request is being served are ignored. After the last response byte is accepted, the block is idle and decodes the next six bytes as a new command.
- R12: While reset is active and after its release, id_ready, rsp_valid and unsup_pulse are low. A reset in the middle of a response abandons it.
- R13: After a serial page request, id_ready takes exactly FIELD_LEN characters. A character offered while id_ready is low has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command byte strobe |
| cmd_byte | input | 8 | Command block byte |
| cfg_qual | input | 3 | Qualifier for response byte 0 bits 7:5 |
| cfg_type | input | 5 | Device type for response byte 0 bits 4:0 |
| id_valid | input | 1 | Identify character offered |
| id_byte | input | 8 | Identify character |
| id_ready | output | 1 | Block accepts an identify character |
| rsp_valid | output | 1 | Response byte available |
| rsp_byte | output | 8 | Response byte |
| rsp_ready | input | 1 | Consumer takes the response byte |
| unsup_pulse | output | 1 | One-cycle flag for an unsupported page request |

## Verification
A wrong command-byte counter misplaces the opcode, flag or page of the next command. That shows at once as a missing response, a stray flag pulse or a wrong identify-read count on the very next request. A wrong kept counter or buffer slot index corrupts byte 3 or a serial byte within the response that follows the fill. A wrong length limit shows as one byte too many or too few at the end of a stream. Stalls applied while a byte is pending expose any byte that changes under backpressure in the cycle after the stall begins.

// File: rtl/snp_pkg.sv
package snp_pkg;
   localparam logic [7:0] OPC_INQ     = 8'h12;
   localparam logic [7:0] PAGE_SERIAL = 8'h80;
   localparam logic [7:0] CH_NUL      = 8'h00;
   localparam logic [7:0] CH_SPACE    = 8'h20;
   localparam int         HDR_LEN     = 4;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_FILL = 2'd1,
      ST_SEND = 2'd2
   } snp_state_e;

   typedef struct packed {
      logic       vpd;     // inquiry with the vital-product-data bit set
      logic       serial;  // vpd request for the serial number page
      logic [7:0] alloc;   // allocation length
   } snp_cmd_t;
endpackage

// File: rtl/snp_cmd_decode.sv
module snp_cmd_decode
   import snp_pkg::*;
#(
   parameter int CMD_LEN = 6
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       accept_en,
   input  logic       cmd_valid,
   input  logic [7:0] cmd_byte,
   output logic       cmd_done,
   output snp_cmd_t   cmd
);
   localparam int IDX_W     = $clog2(CMD_LEN);
   localparam int POS_OP    = 0;
   localparam int POS_FLAGS = 1;
   localparam int POS_PAGE  = 2;
   localparam int POS_ALLOC = 4;

   generate
      if (CMD_LEN < POS_ALLOC + 1) begin : g_bad_len
         $error("snp_cmd_decode: CMD_LEN too small for the allocation byte");
      end
   endgenerate

   logic [IDX_W-1:0] idx_q;
   logic [7:0]       op_q;
   logic             evpd_q;
   logic [7:0]       page_q;
   logic [7:0]       alloc_q;
   logic             done_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         idx_q   <= '0;
         op_q    <= '0;
         evpd_q  <= 1'b0;
         page_q  <= '0;
         alloc_q <= '0;
         done_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (accept_en && cmd_valid) begin
            if (idx_q == IDX_W'(POS_OP))    op_q    <= cmd_byte;
            if (idx_q == IDX_W'(POS_FLAGS)) evpd_q  <= cmd_byte[0];
            if (idx_q == IDX_W'(POS_PAGE))  page_q  <= cmd_byte;
            if (idx_q == IDX_W'(POS_ALLOC)) alloc_q <= cmd_byte;
            if (idx_q == IDX_W'(CMD_LEN - 1)) begin
               idx_q  <= '0;
               done_q <= 1'b1;
            end else begin
               idx_q <= idx_q + 1'b1;
            end
         end
      end
   end

   assign cmd_done   = done_q;
   assign cmd.vpd    = (op_q == OPC_INQ) && evpd_q;
   assign cmd.serial = (op_q == OPC_INQ) && evpd_q && (page_q == PAGE_SERIAL);
   assign cmd.alloc  = alloc_q;

   // R11: a completed command is reported once; the top blocks capture meanwhile
   p_done_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_done |=> !cmd_done);
endmodule

// File: rtl/snp_char_filter.sv
module snp_char_filter
   import snp_pkg::*;
#(
   parameter int FIELD_LEN  = 20,
   parameter bit DROP_SPACE = 1'b1,
   localparam int CNT_W = $clog2(FIELD_LEN + 1),
   localparam int IDX_W = $clog2(FIELD_LEN)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             take,
   input  logic [7:0]       ch,
   output logic             last_take,
   output logic [CNT_W-1:0] kept_cnt,
   input  logic [IDX_W-1:0] rd_idx,
   output logic [7:0]       rd_char
);
   logic             keep;
   logic [CNT_W-1:0] kept_q;
   logic [CNT_W-1:0] seen_q;
   logic [FIELD_LEN*8-1:0] flat;

   generate
      if (DROP_SPACE) begin : g_drop_nul_space
         assign keep = (ch != CH_NUL) && (ch != CH_SPACE);
      end else begin : g_drop_nul_only
         assign keep = (ch != CH_NUL);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         kept_q <= '0;
         seen_q <= '0;
      end else if (clear) begin
         kept_q <= '0;
         seen_q <= '0;
      end else if (take) begin
         seen_q <= seen_q + 1'b1;
         if (keep) kept_q <= kept_q + 1'b1;
      end
   end

   generate
      for (genvar i = 0; i < FIELD_LEN; i++) begin : g_slot
         logic [7:0] slot_q;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               slot_q <= '0;
            end else if (!clear && take && keep && (kept_q == CNT_W'(i))) begin
               slot_q <= ch;
            end
         end
         assign flat[i*8 +: 8] = slot_q;
      end
   endgenerate

   assign last_take = take && (seen_q == CNT_W'(FIELD_LEN - 1));
   assign kept_cnt  = kept_q;
   assign rd_char   = (int'(rd_idx) < FIELD_LEN) ? flat[{rd_idx, 3'b000} +: 8] : 8'h00;

   // R5: a null or space never advances the kept count
   p_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (take && !clear && ((ch == CH_NUL) || (ch == CH_SPACE)))
      |=> (kept_cnt == $past(kept_cnt)));
   // R6: the count never exceeds the field length
   p_count_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
      int'(kept_cnt) <= FIELD_LEN);
endmodule

// File: rtl/snp_resp_framer.sv
module snp_resp_framer
   import snp_pkg::*;
#(
   parameter int FIELD_LEN = 20,
   localparam int CNT_W = $clog2(FIELD_LEN + 1),
   localparam int IDX_W = $clog2(FIELD_LEN),
   localparam int POS_W = $clog2(FIELD_LEN + HDR_LEN + 1)
) (
   input  logic [POS_W-1:0] pos,
   input  logic [2:0]       cfg_qual,
   input  logic [4:0]       cfg_type,
   input  logic [CNT_W-1:0] kept_cnt,
   input  logic [7:0]       rd_char,
   output logic [IDX_W-1:0] rd_idx,
   output logic [7:0]       byte_out
);
   logic [POS_W-1:0] body_pos;

   assign body_pos = pos - POS_W'(HDR_LEN);
   assign rd_idx   = body_pos[IDX_W-1:0];

   always_comb begin
      if (pos == POS_W'(0))      byte_out = {cfg_qual, cfg_type};
      else if (pos == POS_W'(1)) byte_out = PAGE_SERIAL;
      else if (pos == POS_W'(2)) byte_out = 8'h00;
      else if (pos == POS_W'(3)) byte_out = 8'(kept_cnt);
      else                       byte_out = rd_char;
   end
endmodule

// File: rtl/sn_page_responder.sv
module sn_page_responder
   import snp_pkg::*;
#(
   parameter int FIELD_LEN  = 20,
   parameter int CMD_LEN    = 6,
   parameter bit DROP_SPACE = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cmd_valid,
   input  logic [7:0] cmd_byte,
   input  logic [2:0] cfg_qual,
   input  logic [4:0] cfg_type,
   input  logic       id_valid,
   input  logic [7:0] id_byte,
   output logic       id_ready,
   output logic       rsp_valid,
   output logic [7:0] rsp_byte,
   input  logic       rsp_ready,
   output logic       unsup_pulse
);
   localparam int CNT_W = $clog2(FIELD_LEN + 1);
   localparam int IDX_W = $clog2(FIELD_LEN);
   localparam int POS_W = $clog2(FIELD_LEN + HDR_LEN + 1);

   generate
      if (FIELD_LEN < 2 || FIELD_LEN > 251) begin : g_bad_field
         $error("sn_page_responder: FIELD_LEN must lie in 2..251");
      end
   endgenerate

   snp_state_e       state_q;
   logic [POS_W-1:0] pos_q;
   logic             unsup_q;
   logic             cmd_done;
   snp_cmd_t         cmd;
   logic             accept_en;
   logic             fill_clear;
   logic             take;
   logic             last_take;
   logic [CNT_W-1:0] kept_cnt;
   logic [IDX_W-1:0] rd_idx;
   logic [7:0]       rd_char;
   logic [8:0]       full_len;
   logic [8:0]       alloc_ext;
   logic [8:0]       resp_len;
   logic             pos_last;

   assign accept_en  = (state_q == ST_IDLE) && !cmd_done;
   assign fill_clear = (state_q == ST_IDLE) && cmd_done && cmd.serial && (cmd.alloc != 8'h00);
   assign id_ready   = (state_q == ST_FILL);
   assign take       = id_ready && id_valid;
   assign rsp_valid  = (state_q == ST_SEND);
   assign unsup_pulse = unsup_q;

   snp_cmd_decode #(.CMD_LEN(CMD_LEN)) u_decode (
      .clk       (clk),
      .rst_n     (rst_n),
      .accept_en (accept_en),
      .cmd_valid (cmd_valid),
      .cmd_byte  (cmd_byte),
      .cmd_done  (cmd_done),
      .cmd       (cmd)
   );

   snp_char_filter #(.FIELD_LEN(FIELD_LEN), .DROP_SPACE(DROP_SPACE)) u_filter (
      .clk       (clk),
      .rst_n     (rst_n),
      .clear     (fill_clear),
      .take      (take),
      .ch        (id_byte),
      .last_take (last_take),
      .kept_cnt  (kept_cnt),
      .rd_idx    (rd_idx),
      .rd_char   (rd_char)
   );

   snp_resp_framer #(.FIELD_LEN(FIELD_LEN)) u_framer (
      .pos      (pos_q),
      .cfg_qual (cfg_qual),
      .cfg_type (cfg_type),
      .kept_cnt (kept_cnt),
      .rd_char  (rd_char),
      .rd_idx   (rd_idx),
      .byte_out (rsp_byte)
   );

   assign full_len  = 9'(kept_cnt) + 9'(HDR_LEN);
   assign alloc_ext = {1'b0, cmd.alloc};
   assign resp_len  = (alloc_ext < full_len) ? alloc_ext : full_len;
   assign pos_last  = (9'(pos_q) == (resp_len - 9'd1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         pos_q   <= '0;
         unsup_q <= 1'b0;
      end else begin
         unsup_q <= (state_q == ST_IDLE) && cmd_done && cmd.vpd && !cmd.serial;
         unique case (state_q)
            ST_IDLE: begin
               pos_q <= '0;
               if (fill_clear) state_q <= ST_FILL;
            end
            ST_FILL: begin
               if (last_take) begin
                  state_q <= ST_SEND;
                  pos_q   <= '0;
               end
            end
            ST_SEND: begin
               if (rsp_ready) begin
                  if (pos_last) begin
                     state_q <= ST_IDLE;
                     pos_q   <= '0;
                  end else begin
                     pos_q <= pos_q + 1'b1;
                  end
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   // R10: a stalled byte stays offered and unchanged
   p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_byte)));
   // R8: the unsupported-page flag lasts one cycle
   p_unsup_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
      unsup_pulse |=> !unsup_pulse);
   // R7: no byte is offered at or beyond the allocation length
   p_alloc_limit_r7: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> (9'(pos_q) < alloc_ext));
   // R13: identify reads and response bytes never overlap
   p_fill_vs_send_r13: assert property (@(posedge clk) disable iff (!rst_n)
      take |=> !(rsp_valid && $past(!last_take)));
endmodule

// File: tb/sn_page_responder_tb.sv
`timescale 1ns/1ps
module sn_page_responder_tb;
   localparam int FL = 20;

   typedef struct packed {
      logic [7:0]      op;
      logic [7:0]      flags;
      logic [7:0]      page;
      logic [7:0]      alloc;
      logic [FL*8-1:0] field;
   } vec_t;

   localparam int NV = 12;
   localparam vec_t VECS [NV] = '{
      '{8'h12, 8'h01, 8'h80, 8'hFF, "713 740             "},
      '{8'h12, 8'h01, 8'h80, 8'h40, "                    "},
      '{8'h12, 8'hE1, 8'h80, 8'h18, "ABCDEFGHIJKLMNOPQRST"},
      '{8'h12, 8'h01, 8'h80, 8'h02, "SN12345678          "},
      '{8'h12, 8'h01, 8'h80, 8'h00, "713 740             "},
      '{8'h12, 8'h01, 8'h83, 8'hFF, "713 740             "},
      '{8'h12, 8'h00, 8'h80, 8'hFF, "713 740             "},
      '{8'h28, 8'h01, 8'h80, 8'hFF, "713 740             "},
      '{8'h12, 8'h01, 8'h80, 8'hFF, {8'h00, "A", 8'h00, " B", {15{8'h00}}}},
      '{8'h12, 8'h01, 8'h80, 8'h05, "713 740             "},
      '{8'h12, 8'h01, 8'h80, 8'h09, {" ", 8'h1F, 8'h21, 8'h01, 8'hFF, 8'h80, {14{8'h20}}}},
      '{8'h12, 8'h01, 8'h80, 8'h17, "ABCDEFGHIJKLMNOPQRST"}
   };

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cmd_valid = 1'b0;
   logic [7:0] cmd_byte = '0;
   logic [2:0] cfg_qual = 3'b000;
   logic [4:0] cfg_type = 5'h0E;
   logic       id_valid = 1'b0;
   logic [7:0] id_byte = '0;
   logic       id_ready;
   logic       rsp_valid;
   logic [7:0] rsp_byte;
   logic       rsp_ready = 1'b0;
   logic       unsup_pulse;

   int n_chk = 0;
   int n_err = 0;
   bit finished = 1'b0;

   always #2 clk = ~clk;

   sn_page_responder u_dut (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_byte(cmd_byte),
      .cfg_qual(cfg_qual), .cfg_type(cfg_type), .id_valid(id_valid), .id_byte(id_byte),
      .id_ready(id_ready), .rsp_valid(rsp_valid), .rsp_byte(rsp_byte),
      .rsp_ready(rsp_ready), .unsup_pulse(unsup_pulse)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp, input string what);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic logic [7:0] fchar(input vec_t v, input int i);
      return v.field[(FL-1-i)*8 +: 8];
   endfunction

   task automatic send_cmd(input vec_t v);
      logic [7:0] b [6];
      b[0] = v.op; b[1] = v.flags; b[2] = v.page; b[3] = 8'h00; b[4] = v.alloc; b[5] = 8'h00;
      for (int i = 0; i < 6; i++) begin
         @(negedge clk);
         cmd_valid = 1'b1;
         cmd_byte  = b[i];
      end
   endtask

   task automatic run_vec(input vec_t v, input bit noise, input bit stall);
      logic [7:0] exp_b [FL+4];
      logic [7:0] got [32];
      int kept, full, exp_len, exp_id, exp_unsup, n_got, n_id, n_unsup;
      bit serial, prev_v, prev_r;
      logic [7:0] prev_b;
      serial    = (v.op == 8'h12) && v.flags[0] && (v.page == 8'h80);
      exp_unsup = ((v.op == 8'h12) && v.flags[0] && (v.page != 8'h80)) ? 1 : 0;
      kept = 0;
      for (int i = 0; i < FL; i++) begin
         if (fchar(v, i) != 8'h00 && fchar(v, i) != 8'h20) begin
            exp_b[4+kept] = fchar(v, i);
            kept++;
         end
      end
      exp_b[0] = {cfg_qual, cfg_type};
      exp_b[1] = 8'h80;
      exp_b[2] = 8'h00;
      exp_b[3] = 8'(kept);
      full    = kept + 4;
      exp_len = (serial && v.alloc != 0) ? ((int'(v.alloc) < full) ? int'(v.alloc) : full) : 0;
      exp_id  = (serial && v.alloc != 0) ? FL : 0;
      n_got = 0; n_id = 0; n_unsup = 0; prev_v = 1'b0; prev_r = 1'b0; prev_b = '0;
      send_cmd(v);
      for (int c = 0; c < 120; c++) begin
         bit rdy;
         @(negedge clk);
         if (unsup_pulse) n_unsup++;
         if (prev_v && !prev_r)
            check(rsp_valid && rsp_byte == prev_b, "R10", int'(rsp_byte), int'(prev_b), "stalled byte");
         rdy = stall ? ((c % 3) != 1) : 1'b1;
         rsp_ready = rdy;
         if (rsp_valid && rdy) begin
            if (n_got < 32) got[n_got] = rsp_byte;
            n_got++;
         end
         prev_v = rsp_valid; prev_r = rdy; prev_b = rsp_byte;
         if (id_ready) begin
            id_valid = 1'b1;
            id_byte  = (n_id < FL) ? fchar(v, n_id) : 8'h5A;
            n_id++;
         end else begin
            id_valid = 1'b1;      // R13: offered while not ready, must be ignored
            id_byte  = 8'h5A;
         end
         cmd_valid = noise && (id_ready || rsp_valid);
         cmd_byte  = 8'h12;
      end
      @(negedge clk);
      cmd_valid = 1'b0; id_valid = 1'b0; rsp_ready = 1'b0;
      check(n_got == exp_len, serial ? "R7" : (exp_unsup != 0 ? "R8" : (v.op != 8'h12 ? "R1" : "R9")),
            n_got, exp_len, "response length");
      check(n_unsup == exp_unsup, "R8", n_unsup, exp_unsup, "unsupported pulses");
      check(n_id == exp_id, "R13", n_id, exp_id, "identify characters taken");
      check(!rsp_valid && !id_ready, "R11", int'(rsp_valid), 0, "idle after response");
      for (int i = 0; i < exp_len && i < n_got; i++) begin
         string r;
         r = (i == 0) ? "R3" : (i < 3) ? "R4" : (i == 3) ? "R6" : "R5";
         check(got[i] == exp_b[i], r, int'(got[i]), int'(exp_b[i]), $sformatf("byte %0d", i));
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_chk++; n_err++;
         $display("FAIL R2 watchdog: actual hung expected completion");
         $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      check(!rsp_valid && !id_ready && !unsup_pulse, "R12", int'({rsp_valid, id_ready, unsup_pulse}), 0, "in reset");
      rst_n = 1'b1;
      @(negedge clk);
      check(!rsp_valid && !id_ready && !unsup_pulse, "R12", int'({rsp_valid, id_ready, unsup_pulse}), 0, "after reset");

      // table walk covers R1..R9 with backpressure on every vector
      for (int k = 0; k < NV; k++) run_vec(VECS[k], 1'b0, 1'b1);

      // R11: command bytes during service are ignored, next command decodes cleanly
      run_vec(VECS[0], 1'b1, 1'b0);
      run_vec(VECS[2], 1'b0, 1'b0);

      // R3: configuration inputs reach byte 0
      cfg_qual = 3'b101; cfg_type = 5'h1F;
      run_vec(VECS[9], 1'b0, 1'b0);

      // R12: reset in the middle of a response
      begin
         bit seen;
         int fed;
         seen = 1'b0; fed = 0;
         send_cmd(VECS[0]);
         for (int c = 0; c < 60 && !seen; c++) begin
            @(negedge clk);
            cmd_valid = 1'b0;
            rsp_ready = 1'b0;
            if (rsp_valid) seen = 1'b1;
            id_valid = id_ready;
            id_byte  = (fed < FL) ? fchar(VECS[0], fed) : 8'h5A;
            if (id_ready) fed++;
         end
         id_valid = 1'b0;
         check(seen, "R2", int'(seen), 1, "response offered before reset");
         rst_n = 1'b0;
         @(negedge clk);
         check(!rsp_valid && !id_ready, "R12", int'({rsp_valid, id_ready}), 0, "reset mid response");
         rst_n = 1'b1;
         @(negedge clk);
         check(!rsp_valid, "R12", int'(rsp_valid), 0, "response abandoned");
      end
      run_vec(VECS[0], 1'b0, 1'b0);

      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end
endmodule